// File: doc/BRIEF.md
# Ethernet Receive Header Classifier

This block sits on a byte-wide receive stream and classifies each frame from its leading header bytes. Each beat carries a valid qualifier and start and end markers. The block takes the 48-bit destination address and checks it against the all-ones broadcast value and against a table of programmable station addresses. It finds the type/length field, which moves past zero, one or two VLAN tags, and looks that field up in a table of programmable type values. It also reports the tag's control fields.

When a frame ends, the block presents one status word. A one-cycle strobe marks it, and the word holds until the next frame ends. Software loads both tables through a small write port. A write is staged and reaches the comparators at the next start of frame, so a frame is always classified with the settings it started under. The stacked-tag mode input is sampled at start of frame in the same way.

Top module: `rx_hdr_classifier`

## Requirements
- R1: `st_bcast_o` is 1 exactly when the frame carried at least 6 bytes and bytes 0..5 are all 0xFF.
- R2: Address entry i matches when its enable bit is set and its 48-bit value equals bytes 0..5, with byte 0 compared against bits 47:40. A match sets `st_addr_hit_o` and reports `st_addr_idx_o` = i, so 00 is entry 0 and 11 is entry 3. Disabled entries never match.
- R3: When several address entries match, the highest-numbered one is reported. With no match, `st_addr_idx_o` is 00.
- R4: The type field (first byte in bits 15:8) is matched against the type table. Enable gating, index encoding, highest-entry-wins and idx 00 on no match all work as in R2/R3.
- R5: The type field is taken from bytes 12-13 of an untagged frame, from bytes 16-17 after one tag, and from bytes 20-21 after two tags.
- R6: With stacked mode off, a frame with 0x8100 in bytes 12-13 sets `st_vlan_o`. The fields then come from bytes 14-15: `st_pcp_o` is bits 15:13 and `st_cfi_o` is bit 12. `st_prio_tag_o` is set when the 12-bit identifier is zero. If `st_vlan_o` is 0, then `st_prio_tag_o`, `st_pcp_o` and `st_cfi_o` are 0.
- R7: With stacked mode on, an outer tag is recognized when bytes 12-13 hold 0x8100 or 0x88A8. The VLAN flags and fields come only from a second tag: bytes 16-17 must hold 0x8100, and the tag control word is in bytes 18-19. An outer tag without an inner 0x8100 tag counts as one tag and leaves `st_vlan_o` at 0.
- R8: A frame that ends before byte 5 reports no broadcast and no address hit. A frame that ends before its type field is complete reports no type hit. A tag whose control word is incomplete does not set `st_vlan_o`.
- R9: The status outputs change only in the cycle after an end-of-frame beat. In that cycle `st_valid_o` is 1 for exactly one cycle, and otherwise it is 0.
- R10: A table write takes effect from the next start of frame. A frame already in progress keeps the table contents it started with.
- R11: After reset, all status outputs are 0 and every table entry is disabled.
- R12: Beats with `rx_valid_i` low are ignored. Beats that come after an end of frame and before the next start of frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 3 | Bit 2: 0 = address table, 1 = type table; bits 1:0 select the entry |
| cfg_en_i | input | 1 | Enable bit for the written entry |
| cfg_data_i | input | 48 | Entry value; the type table uses bits 15:0 |
| vlan_stack_i | input | 1 | Stacked-tag mode, sampled at start of frame |
| rx_valid_i | input | 1 | Beat valid |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_data_i | input | 8 | Received byte |
| st_valid_o | output | 1 | One-cycle strobe: new status |
| st_bcast_o | output | 1 | Broadcast destination |
| st_addr_hit_o | output | 1 | Address table hit |
| st_addr_idx_o | output | 2 | Winning address entry |
| st_type_hit_o | output | 1 | Type table hit |
| st_type_idx_o | output | 2 | Winning type entry |
| st_vlan_o | output | 1 | VLAN tag detected |
| st_prio_tag_o | output | 1 | Priority-only tag (null identifier) |
| st_pcp_o | output | 3 | Tag priority |
| st_cfi_o | output | 1 | Tag canonical format bit |

## Verification
Some properties hold on every cycle, and the assertions check them continuously. The status strobe follows an end-of-frame beat, and the status holds whenever the strobe is low. The priority-tag flag and the tag fields stay zero without a detected tag, and each index stays 00 without a hit. Other behaviour shows only in the bench's frame scenarios: which entry wins an overlap, where the type field is found for each tag layout, how truncated frames behave, how stacked mode changes the flags, and whether a table write stays out of a frame already in progress.

// File: rtl/rx_hdr_pkg.sv
package rx_hdr_pkg;
  localparam int unsigned ADDR_W    = 48;
  localparam int unsigned TYPE_W    = 16;
  localparam int unsigned HDR_BYTES = 22;
  localparam int unsigned LEN_W     = $clog2(HDR_BYTES + 1);
  localparam logic [TYPE_W-1:0] TPID_C = 16'h8100;

  typedef struct packed {
    logic       vlan;
    logic       prio_tag;
    logic [2:0] pcp;
    logic       cfi;
  } vlan_info_t;
endpackage

// File: rtl/rx_hdr_cfg.sv
module rx_hdr_cfg #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 48,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IW-1:0]         idx_i,
  input  logic                  en_i,
  input  logic [W-1:0]          data_i,
  input  logic                  load_i,
  output logic [N-1:0]          act_en_o,
  output logic [N-1:0][W-1:0]   act_val_o
);
  logic [N-1:0]        stg_en_q;
  logic [N-1:0][W-1:0] stg_val_q;

  // staged writes reach the comparators only at start of frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_en_q  <= '0;
      stg_val_q <= '0;
      act_en_o  <= '0;
      act_val_o <= '0;
    end else begin
      if (we_i) begin
        stg_en_q[idx_i]  <= en_i;
        stg_val_q[idx_i] <= data_i;
      end
      if (load_i) begin
        act_en_o  <= stg_en_q;
        act_val_o <= stg_val_q;
      end
    end
  end
endmodule

// File: rtl/rx_hdr_capture.sv
module rx_hdr_capture
  import rx_hdr_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          sof_i,
  input  logic                          eof_i,
  input  logic [7:0]                    data_i,
  output logic                          sof_o,
  output logic                          eof_o,
  output logic [HDR_BYTES-1:0][7:0]     hdr_o,
  output logic [LEN_W-1:0]              len_o
);
  logic [HDR_BYTES-1:0][7:0] hdr_q;
  logic [LEN_W-1:0]          pos_q, base_pos;
  logic                      in_frame_q, beat;

  assign beat  = valid_i && (sof_i || in_frame_q);
  assign sof_o = valid_i && sof_i;
  assign eof_o = beat && eof_i;

  // header view including the byte on the current beat
  always_comb begin
    hdr_o    = sof_i ? '0 : hdr_q;
    base_pos = sof_i ? '0 : pos_q;
    len_o    = base_pos;
    if (beat && (base_pos < LEN_W'(HDR_BYTES))) begin
      hdr_o[base_pos] = data_i;
      len_o           = base_pos + LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q      <= '0;
      pos_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (beat) begin
      hdr_q      <= hdr_o;
      pos_q      <= len_o;
      in_frame_q <= !eof_i;
    end
  end
endmodule

// File: rtl/rx_hdr_prio_match.sv
module rx_hdr_prio_match #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 48,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [W-1:0]        key_i,
  input  logic [N-1:0]        en_i,
  input  logic [N-1:0][W-1:0] val_i,
  output logic                hit_o,
  output logic [IW-1:0]       idx_o
);
  // later entries override earlier: highest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (en_i[i] && (val_i[i] == key_i)) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rx_hdr_classifier.sv
module rx_hdr_classifier
  import rx_hdr_pkg::*;
#(
  parameter int unsigned N_ADDR = 4,
  parameter int unsigned N_TYPE = 4,
  parameter logic [15:0] S_TPID = 16'h88A8,
  localparam int unsigned AIW   = (N_ADDR > 1) ? $clog2(N_ADDR) : 1,
  localparam int unsigned TIW   = (N_TYPE > 1) ? $clog2(N_TYPE) : 1,
  localparam int unsigned SEL_W = ((AIW > TIW) ? AIW : TIW) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              vlan_stack_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  output logic              st_valid_o,
  output logic              st_bcast_o,
  output logic              st_addr_hit_o,
  output logic [AIW-1:0]    st_addr_idx_o,
  output logic              st_type_hit_o,
  output logic [TIW-1:0]    st_type_idx_o,
  output logic              st_vlan_o,
  output logic              st_prio_tag_o,
  output logic [2:0]        st_pcp_o,
  output logic              st_cfi_o
);
  logic                          sof, eof;
  logic [HDR_BYTES-1:0][7:0]     hdr;
  logic [LEN_W-1:0]              len;
  logic [N_ADDR-1:0]             a_en;
  logic [N_ADDR-1:0][ADDR_W-1:0] a_val;
  logic [N_TYPE-1:0]             t_en;
  logic [N_TYPE-1:0][TYPE_W-1:0] t_val;
  logic                          stack_q;

  rx_hdr_capture u_cap (
    .clk_i, .rst_ni,
    .valid_i (rx_valid_i), .sof_i (rx_sof_i), .eof_i (rx_eof_i), .data_i (rx_data_i),
    .sof_o (sof), .eof_o (eof), .hdr_o (hdr), .len_o (len)
  );

  rx_hdr_cfg #(.N(N_ADDR), .W(ADDR_W)) u_acfg (
    .clk_i, .rst_ni,
    .we_i   (cfg_we_i && !cfg_sel_i[SEL_W-1]),
    .idx_i  (cfg_sel_i[AIW-1:0]),
    .en_i   (cfg_en_i),
    .data_i (cfg_data_i),
    .load_i (sof),
    .act_en_o (a_en), .act_val_o (a_val)
  );

  rx_hdr_cfg #(.N(N_TYPE), .W(TYPE_W)) u_tcfg (
    .clk_i, .rst_ni,
    .we_i   (cfg_we_i && cfg_sel_i[SEL_W-1]),
    .idx_i  (cfg_sel_i[TIW-1:0]),
    .en_i   (cfg_en_i),
    .data_i (cfg_data_i[TYPE_W-1:0]),
    .load_i (sof),
    .act_en_o (t_en), .act_val_o (t_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  stack_q <= 1'b0;
    else if (sof) stack_q <= vlan_stack_i;
  end

  // field decode on the end-of-frame view
  logic [ADDR_W-1:0] dst;
  logic [15:0]       t12, t16, tci, type_key;
  logic              outer, inner, addr_ok, type_ok;
  vlan_info_t        vinfo;

  assign dst = {hdr[0], hdr[1], hdr[2], hdr[3], hdr[4], hdr[5]};
  assign t12 = {hdr[12], hdr[13]};
  assign t16 = {hdr[16], hdr[17]};
  assign addr_ok = len >= LEN_W'(6);
  assign outer = (len >= LEN_W'(14)) &&
                 ((t12 == TPID_C) || (stack_q && (t12 == S_TPID)));
  assign inner = stack_q && outer && (len >= LEN_W'(18)) && (t16 == TPID_C);
  assign tci   = stack_q ? {hdr[18], hdr[19]} : {hdr[14], hdr[15]};

  always_comb begin
    if (inner) begin
      type_key = {hdr[20], hdr[21]};
      type_ok  = len >= LEN_W'(22);
    end else if (outer) begin
      type_key = t16;
      type_ok  = len >= LEN_W'(18);
    end else begin
      type_key = t12;
      type_ok  = len >= LEN_W'(14);
    end
    vinfo = '0;
    if (stack_q ? (inner && (len >= LEN_W'(20))) : (outer && (len >= LEN_W'(16)))) begin
      vinfo.vlan     = 1'b1;
      vinfo.prio_tag = (tci[11:0] == 12'h000);
      vinfo.pcp      = tci[15:13];
      vinfo.cfi      = tci[12];
    end
  end

  logic           a_hit, t_hit;
  logic [AIW-1:0] a_idx;
  logic [TIW-1:0] t_idx;

  rx_hdr_prio_match #(.N(N_ADDR), .W(ADDR_W)) u_amatch (
    .key_i (dst), .en_i (a_en), .val_i (a_val), .hit_o (a_hit), .idx_o (a_idx)
  );

  rx_hdr_prio_match #(.N(N_TYPE), .W(TYPE_W)) u_tmatch (
    .key_i (type_key), .en_i (t_en), .val_i (t_val), .hit_o (t_hit), .idx_o (t_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_valid_o    <= 1'b0;
      st_bcast_o    <= 1'b0;
      st_addr_hit_o <= 1'b0;
      st_addr_idx_o <= '0;
      st_type_hit_o <= 1'b0;
      st_type_idx_o <= '0;
      st_vlan_o     <= 1'b0;
      st_prio_tag_o <= 1'b0;
      st_pcp_o      <= '0;
      st_cfi_o      <= 1'b0;
    end else begin
      st_valid_o <= eof;
      if (eof) begin
        st_bcast_o    <= addr_ok && (&dst);
        st_addr_hit_o <= addr_ok && a_hit;
        st_addr_idx_o <= (addr_ok && a_hit) ? a_idx : '0;
        st_type_hit_o <= type_ok && t_hit;
        st_type_idx_o <= (type_ok && t_hit) ? t_idx : '0;
        st_vlan_o     <= vinfo.vlan;
        st_prio_tag_o <= vinfo.prio_tag;
        st_pcp_o      <= vinfo.pcp;
        st_cfi_o      <= vinfo.cfi;
      end
    end
  end
endmodule

// File: rtl/rx_hdr_classifier_chk.sv
module rx_hdr_classifier_chk #(
  parameter int unsigned AIW = 2,
  parameter int unsigned TIW = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rx_valid_i,
  input logic           rx_eof_i,
  input logic           st_valid_o,
  input logic           st_bcast_o,
  input logic           st_addr_hit_o,
  input logic [AIW-1:0] st_addr_idx_o,
  input logic           st_type_hit_o,
  input logic [TIW-1:0] st_type_idx_o,
  input logic           st_vlan_o,
  input logic           st_prio_tag_o,
  input logic [2:0]     st_pcp_o,
  input logic           st_cfi_o
);
  assert_strobe_after_eof_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |-> $past(rx_valid_i && rx_eof_i));

  assert_status_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_valid_o |-> ($stable(st_bcast_o) && $stable(st_addr_hit_o) && $stable(st_addr_idx_o)
                     && $stable(st_type_hit_o) && $stable(st_type_idx_o) && $stable(st_vlan_o)
                     && $stable(st_prio_tag_o) && $stable(st_pcp_o) && $stable(st_cfi_o)));

  assert_prio_needs_vlan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_prio_tag_o |-> st_vlan_o);

  assert_fields_zero_no_vlan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_vlan_o |-> (st_pcp_o == 3'd0 && !st_cfi_o));

  assert_addr_idx_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_addr_hit_o |-> (st_addr_idx_o == '0));

  assert_type_idx_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_type_hit_o |-> (st_type_idx_o == '0));
endmodule

bind rx_hdr_classifier rx_hdr_classifier_chk #(.AIW(AIW), .TIW(TIW)) u_chk (.*);

// File: tb/rx_hdr_classifier_tb_top.sv
`timescale 1ns/1ps
module rx_hdr_classifier_tb_top;
  typedef struct packed {
    logic        stack;
    logic [7:0]  len;
    logic [47:0] dst;
    logic [15:0] t12, w14, t16, w18, t20;
    logic [12:0] exp; // bcast | ahit aidx | thit tidx | vlan prio pcp cfi
  } vec_t;

  localparam logic [47:0] A0 = 48'h0200_0000_0001, A1 = 48'h0200_0000_0002,
                          A3 = 48'h0200_0000_0009, BC = 48'hFFFF_FFFF_FFFF;

  localparam vec_t VEC [14] = '{
    '{1'b0, 8'd64, BC, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 13'b1_000_110_000000}, // R1 R4 overlap T0/T2
    '{1'b0, 8'd60, A0, 16'h86DD, 16'h0, 16'h0, 16'h0, 16'h0, 13'b0_110_101_000000}, // R3 overlap A0/A2
    '{1'b0, 8'd60, A1, 16'h8100, 16'hA123, 16'h0800, 16'h0, 16'h0, 13'b0_101_110_101010}, // R5 R6
    '{1'b0, 8'd60, A3, 16'h8100, 16'h7000, 16'h86DD, 16'h0, 16'h0, 13'b0_000_101_110111}, // R2 disabled, R6 prio
    '{1'b1, 8'd60, A1, 16'h88A8, 16'h0005, 16'h8100, 16'hC000, 16'h0800, 13'b0_101_110_111100}, // R7 R5
    '{1'b1, 8'd60, BC, 16'h8100, 16'hE00A, 16'h8100, 16'h3010, 16'h86DD, 13'b1_000_101_100011}, // R7
    '{1'b1, 8'd60, A0, 16'h88A8, 16'h0000, 16'h86DD, 16'h0, 16'h0, 13'b0_110_101_000000}, // R7 outer only
    '{1'b0, 8'd60, A1, 16'h88A8, 16'h0000, 16'h86DD, 16'h0, 16'h0, 13'b0_101_000_000000}, // R6 no stack tpid
    '{1'b0, 8'd5,  BC, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 13'b0_000_000_000000}, // R8
    '{1'b0, 8'd13, A0, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 13'b0_110_000_000000}, // R8
    '{1'b0, 8'd14, A0, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 13'b0_110_110_000000}, // R8 boundary
    '{1'b0, 8'd17, A3, 16'h8100, 16'h2000, 16'h0800, 16'h0, 16'h0, 13'b0_000_000_110010}, // R8
    '{1'b1, 8'd21, BC, 16'h8100, 16'h0000, 16'h8100, 16'h4001, 16'h0800, 13'b1_000_000_100100}, // R8 R7
    '{1'b1, 8'd60, A1, 16'h8100, 16'h0000, 16'h0800, 16'h0, 16'h0, 13'b0_101_110_000000}  // R7 single
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, stack = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [47:0] cfg_data = '0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic st_valid, st_bcast, st_ahit, st_thit, st_vlan, st_prio, st_cfi;
  logic [1:0] st_aidx, st_tidx;
  logic [2:0] st_pcp;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_hdr_classifier dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel), .cfg_en_i (cfg_en), .cfg_data_i (cfg_data),
    .vlan_stack_i (stack),
    .rx_valid_i (rx_valid), .rx_sof_i (rx_sof), .rx_eof_i (rx_eof), .rx_data_i (rx_data),
    .st_valid_o (st_valid), .st_bcast_o (st_bcast), .st_addr_hit_o (st_ahit),
    .st_addr_idx_o (st_aidx), .st_type_hit_o (st_thit), .st_type_idx_o (st_tidx),
    .st_vlan_o (st_vlan), .st_prio_tag_o (st_prio), .st_pcp_o (st_pcp), .st_cfi_o (st_cfi)
  );

  function automatic logic [12:0] status();
    return {st_bcast, st_ahit, st_aidx, st_thit, st_tidx, st_vlan, st_prio, st_pcp, st_cfi};
  endfunction

  function automatic logic [7:0] byte_at(vec_t v, int i);
    case (i)
      0, 1, 2, 3, 4, 5: return v.dst[47-8*i -: 8];
      12: return v.t12[15:8];  13: return v.t12[7:0];
      14: return v.w14[15:8];  15: return v.w14[7:0];
      16: return v.t16[15:8];  17: return v.t16[7:0];
      18: return v.w18[15:8];  19: return v.w18[7:0];
      20: return v.t20[15:8];  21: return v.t20[7:0];
      default: return (i < 12) ? 8'h10 + 8'(i) : 8'h5A;
    endcase
  endfunction

  task automatic chk(string what, logic [12:0] got, logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic check_status(string tag, logic [12:0] exp);
    logic [12:0] s;
    s = status();
    chk({tag, " R9 strobe"}, {12'd0, st_valid}, 13'd1);
    chk({tag, " R1 broadcast"}, {12'd0, s[12]}, {12'd0, exp[12]});
    chk({tag, " R2/R3 address"}, {10'd0, s[11:9]}, {10'd0, exp[11:9]});
    chk({tag, " R4/R5 type"}, {10'd0, s[8:6]}, {10'd0, exp[8:6]});
    chk({tag, " R6/R7 vlan"}, {7'd0, s[5:0]}, {7'd0, exp[5:0]});
  endtask

  task automatic cfg_write(logic [2:0] sel, logic en, logic [47:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_en = en; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // gap_at: beat index before which two idle cycles with garbage are inserted
  task automatic send(vec_t v, int gap_at, bit wr_a3);
    @(negedge clk);
    stack = v.stack;
    for (int i = 0; i < int'(v.len); i++) begin
      if (i == gap_at) begin
        rx_valid = 1'b0; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'hEE;
        cfg_we = wr_a3; cfg_sel = 3'b011; cfg_en = 1'b1; cfg_data = A3;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == int'(v.len) - 1);
      rx_data = byte_at(v, i);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
  endtask

  initial begin
    vec_t f;
    logic [12:0] last;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset status", {status()[12:1], st_valid}, 13'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 tables disabled after reset
    f = '{1'b0, 8'd20, A0, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0, 13'b0};
    send(f, -1, 1'b0);
    check_status("R11 empty tables", 13'b0);

    cfg_write(3'b000, 1'b1, A0);
    cfg_write(3'b001, 1'b1, A1);
    cfg_write(3'b010, 1'b1, A0);
    cfg_write(3'b011, 1'b0, A3);
    cfg_write(3'b100, 1'b1, 48'h0800);
    cfg_write(3'b101, 1'b1, 48'h86DD);
    cfg_write(3'b110, 1'b1, 48'h0800);
    cfg_write(3'b111, 1'b0, 48'h0806);

    foreach (VEC[k]) begin
      send(VEC[k], -1, 1'b0);
      check_status($sformatf("vec%0d", k), VEC[k].exp);
    end
    last = VEC[13].exp;

    // R9 strobe lasts one cycle, status holds
    @(negedge clk);
    chk("R9 strobe drop", {12'd0, st_valid}, 13'd0);
    chk("R9 status hold", status(), last);

    // R12 beat outside a frame is ignored
    rx_valid = 1'b1; rx_eof = 1'b1; rx_data = 8'hFF;
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0;
    @(negedge clk);
    chk("R12 stray beat strobe", {12'd0, st_valid}, 13'd0);
    chk("R12 stray beat status", status(), last);

    // R12 idle beats inside the address field are ignored
    f = '{1'b0, 8'd30, A0, 16'h86DD, 16'h0, 16'h0, 16'h0, 16'h0, 13'b0};
    send(f, 2, 1'b0);
    check_status("R12 gap", 13'b0_110_101_000000);

    // R10 write during a frame does not affect it
    f = '{1'b0, 8'd30, A3, 16'h0806, 16'h0, 16'h0, 16'h0, 16'h0, 13'b0};
    send(f, 3, 1'b1);
    check_status("R10 in-flight", 13'b0_000_000_000000);
    send(f, -1, 1'b0);
    check_status("R10 next frame", 13'b0_111_000_000000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule